// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is a repeating countdown timer set up through a single 32-bit control word. Software chooses a terminal count, a time source (the system clock or an alternate tick supplied as a one-cycle enable pulse in the system clock domain), and whether a fixed divide-by-4096 prescaler stands in front of the counter. Once enabled, the timer expires every (TC + 1) effective ticks. It reloads on its own after each expiry and keeps running for as long as the enable stays set.

Each expiry sets a sticky pending flag in a separate status word. Software clears the flag by writing 1 to bit 0 of that word. When interrupts are enabled, the pending flag drives one of two request lines, normal or fast, chosen by a bit in the control word. The control word can be written in full in the same write that sets the enable, and the timer then starts from the values of that write.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, and both interrupt outputs are low.
- R2: The control word keeps enable in bit 31, interrupt enable in bit 30, fast select in bit 29, prescaler enable in bit 28, alternate-source select in bit 27 and the terminal count TC in bits 15:0. These bits read back as written, and bits 26:16 read as 0.
- R3: With the system clock as the source and bit 28 clear, the pending flag (status bit 0) is set exactly TC + 1 cycles after the clock edge that samples the enabling write.
- R4: With the system clock as the source and bit 28 set, the pending flag is set exactly 4096 × (TC + 1) cycles after the enabling write.
- R5: With the alternate source selected (bit 27 = 1), the flag is set on the edge that samples the (TC + 1)-th alternate tick, and bit 28 has no effect.
- R6: While the timer stays enabled, it reloads TC after each expiry, so later expiries follow every TC + 1 effective ticks.
- R7: Clearing the enable resets both the countdown and the prescaler, so a later enable always gives a full first period.
- R8: A single write that sets the enable together with a new TC runs the first period with that new TC.
- R9: The pending flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it set. A clear on the same edge as an expiry leaves it set.
- R10: The interrupt outputs are low while bit 30 is 0. When bit 30 is 1, a set pending flag drives the normal output if bit 29 is 0 and the fast output if bit 29 is 1, and never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word read data |
| stat_wr | input | 1 | Write strobe for the status word |
| stat_wdata | input | 32 | Status write data; bit 0 = 1 clears pending |
| stat_rdata | output | 32 | Status read data; bit 0 is the pending flag |
| alt_tick | input | 1 | Alternate time source, one-cycle pulses synchronous to clk |
| irq_normal | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The assertions assume that every input, including the alternate tick, is synchronous to clk and stable around its rising edge, and that the alternate tick is a pulse and not a level. The bench changes all inputs on the falling edge and gives the alternate tick as isolated one-cycle pulses spaced a few cycles apart. It writes control and status as single-cycle strobes and never issues both in the same cycle. It places every pending-flag clear at a cycle it has computed in advance, so that the clear lands either well away from an expiry or exactly on one.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int TC_W     = 16;
    localparam int BIT_EN   = 31;
    localparam int BIT_IE   = 30;
    localparam int BIT_FAST = 29;
    localparam int BIT_PRE  = 28;
    localparam int BIT_ALT  = 27;
    localparam int BIT_PEND = 0;

    typedef struct packed {
        logic            en;
        logic            ie;
        logic            fast;
        logic            pre;
        logic            alt;
        logic [TC_W-1:0] tc;
    } ctrl_t;
endpackage

// File: rtl/timer_ctrl_reg.sv
module timer_ctrl_reg
    import timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [31:0]         wdata_i,
    output ctrl_t               ctrl_o,
    output logic                next_en_o,
    output logic [TC_W-1:0]     next_tc_o,
    output logic [31:0]         rdata_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  unused_wbits;

    assign unused_wbits = &{1'b0, wdata_i[BIT_ALT-1:TC_W]};

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d.en   = wdata_i[BIT_EN];
            ctrl_d.ie   = wdata_i[BIT_IE];
            ctrl_d.fast = wdata_i[BIT_FAST];
            ctrl_d.pre  = wdata_i[BIT_PRE];
            ctrl_d.alt  = wdata_i[BIT_ALT];
            ctrl_d.tc   = wdata_i[TC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_EN]   = ctrl_q.en;
        rdata_o[BIT_IE]   = ctrl_q.ie;
        rdata_o[BIT_FAST] = ctrl_q.fast;
        rdata_o[BIT_PRE]  = ctrl_q.pre;
        rdata_o[BIT_ALT]  = ctrl_q.alt;
        rdata_o[TC_W-1:0] = ctrl_q.tc;
    end

    assign ctrl_o    = ctrl_q;
    assign next_en_o = ctrl_d.en;
    assign next_tc_o = ctrl_d.tc;

    // R2: without a write strobe the stored control fields do not move
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ctrl_q == $past(ctrl_q));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int DIV = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int          PW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            tick_o   = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: divider phase never leaves its range
    a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    // R7: an idle prescaler restarts from phase zero
    a_r7_prescaler_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> st_q.cnt == '0);
endmodule

// File: rtl/timer_counter.sv
module timer_counter
    import timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            next_run_i,
    input  logic            tick_i,
    input  logic [TC_W-1:0] load_val_i,
    input  logic [TC_W-1:0] reload_val_i,
    output logic            expire_o
);
    typedef struct packed {
        logic [TC_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (!run_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                expire_o = 1'b1;
                st_d.cnt = reload_val_i;
            end else begin
                st_d.cnt = st_q.cnt - TC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a tick away from zero moves the count down by one
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && next_run_i && tick_i && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - TC_W'(1));
    // R7: while stopped the count tracks the value to start from
    a_r7_idle_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> st_q.cnt == $past(load_val_i));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic ie_i,
    input  logic fast_i,
    output logic pend_o,
    output logic irq_normal_o,
    output logic irq_fast_o
);
    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend && !clr_i) || expire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o       = st_q.pend;
    assign irq_normal_o = st_q.pend && ie_i && !fast_i;
    assign irq_fast_o   = st_q.pend && ie_i && fast_i;

    // R9: without a clear the flag stays set
    a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_i) |=> st_q.pend);
    // R9: a clear with no expiry drops the flag
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i) |=> !st_q.pend);
    // R9: an expiry always leaves the flag set
    a_r9_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> st_q.pend);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int PRESCALE_DIV = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    output logic [31:0] ctrl_rdata,
    input  logic        stat_wr,
    input  logic [31:0] stat_wdata,
    output logic [31:0] stat_rdata,
    input  logic        alt_tick,
    output logic        irq_normal,
    output logic        irq_fast
);
    ctrl_t           ctrl;
    logic            next_en;
    logic [TC_W-1:0] next_tc;
    logic            pre_run;
    logic            pre_tick;
    logic            cnt_tick;
    logic            expire;
    logic            pend;
    logic            pend_clr;
    logic            unused_sbits;

    assign unused_sbits = &{1'b0, stat_wdata[31:BIT_PEND+1]};
    assign pend_clr     = stat_wr && stat_wdata[BIT_PEND];

    timer_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (ctrl_wr),
        .wdata_i   (ctrl_wdata),
        .ctrl_o    (ctrl),
        .next_en_o (next_en),
        .next_tc_o (next_tc),
        .rdata_o   (ctrl_rdata)
    );

    assign pre_run = ctrl.en && ctrl.pre && !ctrl.alt;

    timer_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (pre_run),
        .tick_o (pre_tick)
    );

    always_comb begin
        if (ctrl.alt)      cnt_tick = alt_tick;
        else if (ctrl.pre) cnt_tick = pre_tick;
        else               cnt_tick = 1'b1;
    end

    timer_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (ctrl.en),
        .next_run_i   (next_en),
        .tick_i       (cnt_tick),
        .load_val_i   (next_tc),
        .reload_val_i (ctrl.tc),
        .expire_o     (expire)
    );

    timer_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire_i     (expire),
        .clr_i        (pend_clr),
        .ie_i         (ctrl.ie),
        .fast_i       (ctrl.fast),
        .pend_o       (pend),
        .irq_normal_o (irq_normal),
        .irq_fast_o   (irq_fast)
    );

    always_comb begin
        stat_rdata           = '0;
        stat_rdata[BIT_PEND] = pend;
    end

    // R10: at most one request line is active
    a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_normal && irq_fast));
    // R10: a request always reflects a pending status bit
    a_r10_req_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_normal || irq_fast) |-> stat_rdata[BIT_PEND]);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        stat_wr = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic [31:0] stat_rdata;
    logic        alt_tick = 1'b0;
    logic        irq_normal, irq_fast;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  prev_pend = 1'b0;
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    interval_timer dut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
        .alt_tick(alt_tick), .irq_normal(irq_normal), .irq_fast(irq_fast)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(bit en, bit ie, bit fast, bit pre, bit alt, int tc);
        return {en, ie, fast, pre, alt, 11'b0, tc[15:0]};
    endfunction

    task automatic wr_ctrl(input logic [31:0] d, output int w);
        ctrl_wdata = d; ctrl_wr = 1'b1; w = cyc;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_stat(input logic [31:0] d);
        stat_wdata = d; stat_wr = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic expect_at(input int c, input string tag);
        exp_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: each rising pending flag is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n && stat_rdata[0] && !prev_pend) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R7 unexpected expiry", cyc, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cyc == e, t, cyc, e);
            end
        end
        prev_pend = stat_rdata[0];
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int w, w2, e1, e3, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_rdata == 0, "R1 ctrl", ctrl_rdata, 0);
        chk(stat_rdata == 0, "R1 stat", stat_rdata, 0);
        chk({irq_normal, irq_fast} == 2'b00, "R1 irq", {irq_normal, irq_fast}, 0);

        // R2 field readback, reserved bits read 0
        wr_ctrl(32'h7FFF_ABCD, w);
        chk(ctrl_rdata == 32'h7800_ABCD, "R2 readback", ctrl_rdata, 32'h7800_ABCD);
        wr_ctrl(32'h0, w);
        chk(ctrl_rdata == 0, "R2 zero", ctrl_rdata, 0);

        // R3 / R6 / R9: system clock, TC = 5
        wr_ctrl(cw(1, 0, 0, 0, 0, 5), w);
        e1 = w + 7;
        expect_at(e1, "R3 first expiry");
        expect_at(e1 + 6, "R6 reload expiry");
        while (exp_q.size() != 1) @(negedge clk);
        chk({irq_normal, irq_fast} == 2'b00, "R10 ie off", {irq_normal, irq_fast}, 0);
        wr_stat(32'hFFFF_FFFE);
        chk(stat_rdata[0] == 1'b1, "R9 write zero keeps", stat_rdata[0], 1);
        wr_stat(32'h1);
        chk(stat_rdata[0] == 1'b0, "R9 clear", stat_rdata[0], 0);
        drain();
        e3 = e1 + 12;
        while (cyc != e3 - 1) @(negedge clk);
        wr_stat(32'h1);
        chk(stat_rdata[0] == 1'b1, "R9 clear on expiry keeps", stat_rdata[0], 1);
        wr_stat(32'h1);
        chk(stat_rdata[0] == 1'b0, "R9 clear after", stat_rdata[0], 0);
        wr_ctrl(32'h0, w);

        // R10 routing
        wr_ctrl(cw(1, 1, 0, 0, 0, 3), w);
        expect_at(w + 5, "R3 TC=3 expiry");
        drain();
        wr_ctrl(cw(0, 1, 0, 0, 0, 3), w);
        chk({irq_normal, irq_fast} == 2'b10, "R10 normal", {irq_normal, irq_fast}, 2'b10);
        wr_ctrl(cw(0, 1, 1, 0, 0, 3), w);
        chk({irq_normal, irq_fast} == 2'b01, "R10 fast", {irq_normal, irq_fast}, 2'b01);
        wr_ctrl(cw(0, 0, 1, 0, 0, 3), w);
        chk({irq_normal, irq_fast} == 2'b00, "R10 disabled", {irq_normal, irq_fast}, 0);
        chk(stat_rdata[0] == 1'b1, "R9 survives disable", stat_rdata[0], 1);
        wr_stat(32'h1);

        // R7 disable restarts countdown
        wr_ctrl(cw(1, 0, 0, 0, 0, 9), w);
        repeat (5) @(negedge clk);
        wr_ctrl(cw(0, 0, 0, 0, 0, 9), w);
        repeat (3) @(negedge clk);
        wr_ctrl(cw(1, 0, 0, 0, 0, 9), w2);
        expect_at(w2 + 11, "R7 full period after restart");
        drain();
        wr_ctrl(32'h0, w);
        wr_stat(32'h1);

        // R4 prescaler
        wr_ctrl(cw(1, 0, 0, 1, 0, 1), w);
        expect_at(w + 1 + 4096 * 2, "R4 prescaled expiry");
        drain();
        wr_ctrl(32'h0, w);
        wr_stat(32'h1);

        // R7 prescaler phase reset
        wr_ctrl(cw(1, 0, 0, 1, 0, 0), w);
        repeat (3000) @(negedge clk);
        wr_ctrl(32'h0, w);
        repeat (2) @(negedge clk);
        wr_ctrl(cw(1, 0, 0, 1, 0, 0), w2);
        expect_at(w2 + 1 + 4096, "R7 prescaler restart");
        drain();
        wr_ctrl(32'h0, w);
        wr_stat(32'h1);

        // R5 alternate source ignores prescaler bit
        wr_ctrl(cw(1, 0, 0, 1, 1, 2), w);
        for (int k = 0; k < 3; k++) begin
            repeat (2) @(negedge clk);
            alt_tick = 1'b1;
            p = cyc;
            if (k == 2) expect_at(p + 1, "R5 alt expiry");
            @(negedge clk);
            alt_tick = 1'b0;
        end
        drain();
        wr_ctrl(32'h0, w);
        wr_stat(32'h1);

        // R8 TC of the enabling write is used
        wr_ctrl(cw(0, 0, 0, 0, 0, 20), w);
        wr_ctrl(cw(1, 0, 0, 0, 0, 2), w);
        expect_at(w + 4, "R8 new TC on enable");
        drain();
        wr_ctrl(32'h0, w);
        wr_stat(32'h1);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule